// File: doc/BRIEF.md
# Two-Phase Last-Level Cache Flush Sequencer

This block flushes a last-level cache that is split across several home-node slices. One start pulse launches a fixed two-phase routine. The routine reaches every slice through one shared register request/response port. In each phase, the block first writes a mode value into the flush-control register of every slice. It then reads each slice's status register in ascending slice order until that slice reports the settled pattern for the mode. Only after all slices confirm the first mode does the second mode begin.

The number of status reads per slice is bounded, and successive reads of the same slice are spaced in time. The spacing is about one microsecond and comes from a cycle counter sized by a clock-frequency parameter. If a slice never settles, the block stops issuing requests and raises a sticky error flag. A clean run ends with a single-cycle done pulse. Only one request is ever in flight. Every request is a one-cycle pulse, and the block waits for the response-valid strobe before moving on. The strobe also acknowledges writes.

Top module: `llc_flush_seq`

## Requirements
- R1: After reset, `done_o`, `err_o` and `req_o` are all low, and no request is issued until `start_i` is seen high.
- R2: A start pulse while idle begins phase one. Phase one writes value 0 to each control register in ascending slice order. Slice numbers run from `FIRST_SLICE` (0x20) upward. The control register address is slice number × `WIN_STRIDE` (0x10000) + `CTRL_OFS` (0x10). All writes are issued before any read.
- R3: After the phase-one writes, the block reads status at slice number × 0x10000 + `STAT_OFS` (0x18), one slice at a time in ascending order. It moves to the next slice only once the low four status bits read 0. Bits above the low four are ignored.
- R4: When every slice has confirmed phase one, the block writes value 3 to all control registers in ascending order. It then polls each slice in ascending order until the low four status bits read 0xC.
- R5: Two successive status reads of the same slice are separated by at least `CLK_MHZ` clock cycles.
- R6: Each slice gets at most `MAX_POLLS` status reads per phase. If the last allowed read still does not match, the block raises `err_o` and issues no further requests.
- R7: `done_o` pulses high for exactly one cycle when both phases complete, and never on a run that ends in error.
- R8: `err_o` stays high until the next accepted start, which clears it.
- R9: A start pulse while a sequence is running is ignored: the request sequence continues unchanged.
- R10: Each request is high for one cycle, and no new request is issued until the response-valid strobe for the previous one has arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, honoured only while idle |
| done_o | output | 1 | One-cycle pulse on successful completion |
| err_o | output | 1 | Sticky poll-timeout flag |
| req_o | output | 1 | Register request strobe |
| we_o | output | 1 | Request is a write when high, a read when low |
| addr_o | output | ADDR_W | Register byte address |
| wdata_o | output | DATA_W | Write data (mode value) |
| rdata_i | input | DATA_W | Read data returned with `rvalid_i` |
| rvalid_i | input | 1 | Response strobe for reads and writes |

## Verification
The bench builds the block with `CLK_MHZ` = 3 and `MAX_POLLS` = 4, and keeps the eight default slices and the address layout. At these values the poll gap is a few cycles and the timeout is reached after four reads. This makes it cheap to sweep every slice in both phases through delays from zero past the limit. That sweep covers the last read that still succeeds, the first delay that times out, and a timeout on the final slice of the final phase. For each run, the bench rebuilds the complete expected request trace arithmetically and compares it entry by entry.

// File: rtl/flush_seq_pkg.sv
package flush_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WR_REQ,
      ST_WR_ACK,
      ST_RD_REQ,
      ST_RD_ACK,
      ST_GAP
   } seq_state_e;

   typedef enum logic {
      PH_SETTLE = 1'b0,
      PH_FINAL  = 1'b1
   } seq_phase_e;

endpackage

// File: rtl/flush_win_addr.sv
module flush_win_addr #(
   parameter int ADDR_W      = 32,
   parameter int IDX_W       = 3,
   parameter int FIRST_SLICE = 'h20,
   parameter int WIN_STRIDE  = 'h10000,
   parameter int CTRL_OFS    = 'h10,
   parameter int STAT_OFS    = 'h18
) (
   input  logic [IDX_W-1:0]  idx_i,
   input  logic              sel_stat_i,
   output logic [ADDR_W-1:0] addr_o
);
   localparam bit STRIDE_POW2 = ((WIN_STRIDE & (WIN_STRIDE - 1)) == 0);

   logic [ADDR_W-1:0] slice_num;
   logic [ADDR_W-1:0] win_base;

   assign slice_num = ADDR_W'(FIRST_SLICE) + ADDR_W'(idx_i);

   generate
      if (STRIDE_POW2) begin : g_shift
         localparam int SH = $clog2(WIN_STRIDE);
         assign win_base = slice_num << SH;
      end else begin : g_mult
         assign win_base = slice_num * ADDR_W'(WIN_STRIDE);
      end
   endgenerate

   assign addr_o = win_base + (sel_stat_i ? ADDR_W'(STAT_OFS) : ADDR_W'(CTRL_OFS));
endmodule

// File: rtl/flush_gap_timer.sv
module flush_gap_timer #(
   parameter int TICKS = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   output logic expired_o
);
   generate
      if (TICKS <= 1) begin : g_none
         logic unused_tmr;
         assign unused_tmr = ^{clk, rst_n, load_i};
         assign expired_o  = 1'b1;
      end else begin : g_count
         localparam int TW = $clog2(TICKS);
         logic [TW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            cnt <= '0;
            else if (load_i)       cnt <= TW'(TICKS - 1);
            else if (cnt != '0)    cnt <= cnt - TW'(1);
         end
         assign expired_o = (cnt == '0);
      end
   endgenerate
endmodule

// File: rtl/flush_poll_cnt.sv
module flush_poll_cnt #(
   parameter int LIMIT = 10000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic inc_i,
   output logic at_limit_o
);
   localparam int PW = $clog2(LIMIT + 1);

   logic [PW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                cnt <= '0;
      else if (clr_i)                            cnt <= '0;
      else if (inc_i && (cnt != PW'(LIMIT)))     cnt <= cnt + PW'(1);
   end

   assign at_limit_o = (cnt == PW'(LIMIT));
endmodule

// File: rtl/llc_flush_seq.sv
module llc_flush_seq
   import flush_seq_pkg::*;
#(
   parameter int N_SLICES    = 8,
   parameter int FIRST_SLICE = 'h20,
   parameter int WIN_STRIDE  = 'h10000,
   parameter int CTRL_OFS    = 'h10,
   parameter int STAT_OFS    = 'h18,
   parameter int ADDR_W      = 32,
   parameter int DATA_W      = 32,
   parameter int CLK_MHZ     = 100,
   parameter int MAX_POLLS   = 10000,
   parameter int STAT_BITS   = 4,
   parameter int MODE_A      = 0,
   parameter int MODE_B      = 3,
   parameter int READY_A     = 'h0,
   parameter int READY_B     = 'hC
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   output logic              done_o,
   output logic              err_o,
   output logic              req_o,
   output logic              we_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [DATA_W-1:0] wdata_o,
   input  logic [DATA_W-1:0] rdata_i,
   input  logic              rvalid_i
);
   localparam int IDX_W = (N_SLICES > 1) ? $clog2(N_SLICES) : 1;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_SLICES - 1);

   generate
      if (N_SLICES < 1)                          begin : g_bad_slices $error("N_SLICES must be at least 1"); end
      if (MAX_POLLS < 1)                         begin : g_bad_polls  $error("MAX_POLLS must be at least 1"); end
      if (CLK_MHZ < 1)                           begin : g_bad_clk    $error("CLK_MHZ must be at least 1"); end
      if (STAT_BITS < 1 || STAT_BITS > DATA_W)   begin : g_bad_stat   $error("STAT_BITS out of range"); end
   endgenerate

   seq_state_e       st;
   seq_phase_e       ph;
   logic [IDX_W-1:0] idx;
   logic             hit;
   logic             gap_load;
   logic             gap_done;
   logic             poll_clr;
   logic             poll_max;
   logic             unused_rdata;

   assign unused_rdata = ^rdata_i;

   always_comb begin
      req_o    = (st == ST_WR_REQ) || (st == ST_RD_REQ);
      we_o     = (st == ST_WR_REQ);
      wdata_o  = (ph == PH_FINAL) ? DATA_W'(MODE_B) : DATA_W'(MODE_A);
      hit      = rdata_i[STAT_BITS-1:0] ==
                 ((ph == PH_FINAL) ? STAT_BITS'(READY_B) : STAT_BITS'(READY_A));
      poll_clr = ((st == ST_WR_ACK) && rvalid_i && (idx == LAST_IDX)) ||
                 ((st == ST_RD_ACK) && rvalid_i && hit);
      gap_load = (st == ST_RD_ACK) && rvalid_i && !hit;
   end

   flush_win_addr #(
      .ADDR_W(ADDR_W), .IDX_W(IDX_W), .FIRST_SLICE(FIRST_SLICE),
      .WIN_STRIDE(WIN_STRIDE), .CTRL_OFS(CTRL_OFS), .STAT_OFS(STAT_OFS)
   ) i_addr (
      .idx_i(idx), .sel_stat_i(st == ST_RD_REQ), .addr_o(addr_o)
   );

   flush_gap_timer #(.TICKS(CLK_MHZ)) i_gap (
      .clk(clk), .rst_n(rst_n), .load_i(gap_load), .expired_o(gap_done)
   );

   flush_poll_cnt #(.LIMIT(MAX_POLLS)) i_polls (
      .clk(clk), .rst_n(rst_n), .clr_i(poll_clr),
      .inc_i(st == ST_RD_REQ), .at_limit_o(poll_max)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         ph     <= PH_SETTLE;
         idx    <= '0;
         done_o <= 1'b0;
         err_o  <= 1'b0;
      end else begin
         done_o <= 1'b0;
         case (st)
            ST_IDLE: if (start_i) begin
               err_o <= 1'b0;
               ph    <= PH_SETTLE;
               idx   <= '0;
               st    <= ST_WR_REQ;
            end
            ST_WR_REQ: st <= ST_WR_ACK;
            ST_WR_ACK: if (rvalid_i) begin
               if (idx == LAST_IDX) begin
                  idx <= '0;
                  st  <= ST_RD_REQ;
               end else begin
                  idx <= idx + IDX_W'(1);
                  st  <= ST_WR_REQ;
               end
            end
            ST_RD_REQ: st <= ST_RD_ACK;
            ST_RD_ACK: if (rvalid_i) begin
               if (hit) begin
                  if (idx == LAST_IDX) begin
                     idx <= '0;
                     if (ph == PH_SETTLE) begin
                        ph <= PH_FINAL;
                        st <= ST_WR_REQ;
                     end else begin
                        done_o <= 1'b1;
                        st     <= ST_IDLE;
                     end
                  end else begin
                     idx <= idx + IDX_W'(1);
                     st  <= ST_RD_REQ;
                  end
               end else if (poll_max) begin
                  err_o <= 1'b1;
                  st    <= ST_IDLE;
               end else begin
                  st <= ST_GAP;
               end
            end
            ST_GAP: if (gap_done) st <= ST_RD_REQ;
            default: st <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/flush_seq_chk.sv
module flush_seq_chk #(
   parameter int ADDR_W     = 32,
   parameter int WIN_STRIDE = 'h10000,
   parameter int CTRL_OFS   = 'h10,
   parameter int STAT_OFS   = 'h18,
   parameter int MAX_POLLS  = 10000
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              done_o,
   input logic              err_o,
   input logic              req_o,
   input logic              we_o,
   input logic [ADDR_W-1:0] addr_o,
   input logic              rvalid_i
);
   logic              pend;
   logic [31:0]       run_cnt;
   logic [ADDR_W-1:0] last_rd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend    <= 1'b0;
         run_cnt <= '0;
         last_rd <= '0;
      end else begin
         if (req_o)         pend <= 1'b1;
         else if (rvalid_i) pend <= 1'b0;
         if (req_o && we_o) run_cnt <= '0;
         else if (req_o) begin
            last_rd <= addr_o;
            run_cnt <= (addr_o == last_rd) ? run_cnt + 32'd1 : 32'd1;
         end
      end
   end

   AST_DONE_SINGLE:  assert property (@(posedge clk) disable iff (!rst_n) done_o |=> !done_o);        // R7
   AST_DONE_NOT_ERR: assert property (@(posedge clk) disable iff (!rst_n) done_o |-> !err_o);         // R7
   AST_ERR_STICKY:   assert property (@(posedge clk) disable iff (!rst_n) (err_o && !start_i) |=> err_o); // R8
   AST_ERR_QUIET:    assert property (@(posedge clk) disable iff (!rst_n) err_o |-> !req_o);          // R6
   AST_REQ_PULSE:    assert property (@(posedge clk) disable iff (!rst_n) req_o |=> !req_o);          // R10
   AST_ONE_OUTSTD:   assert property (@(posedge clk) disable iff (!rst_n) req_o |-> !pend);           // R10
   AST_WR_CTRL:      assert property (@(posedge clk) disable iff (!rst_n)
                        (req_o && we_o) |-> ((addr_o % ADDR_W'(WIN_STRIDE)) == ADDR_W'(CTRL_OFS))); // R2
   AST_RD_STAT:      assert property (@(posedge clk) disable iff (!rst_n)
                        (req_o && !we_o) |-> ((addr_o % ADDR_W'(WIN_STRIDE)) == ADDR_W'(STAT_OFS))); // R3
   AST_POLL_BOUND:   assert property (@(posedge clk) disable iff (!rst_n) run_cnt <= 32'(MAX_POLLS)); // R6
endmodule

bind llc_flush_seq flush_seq_chk #(
   .ADDR_W(ADDR_W), .WIN_STRIDE(WIN_STRIDE), .CTRL_OFS(CTRL_OFS),
   .STAT_OFS(STAT_OFS), .MAX_POLLS(MAX_POLLS)
) i_flush_seq_chk (
   .clk(clk), .rst_n(rst_n), .start_i(start_i), .done_o(done_o), .err_o(err_o),
   .req_o(req_o), .we_o(we_o), .addr_o(addr_o), .rvalid_i(rvalid_i)
);

// File: tb/test_llc_flush_seq.sv
module test_llc_flush_seq;
   localparam int TB_MHZ   = 3;
   localparam int TB_POLLS = 4;
   localparam int NS       = 8;
   localparam int TRMAX    = 1024;

   logic        clk, rst_n, start_i;
   logic        done_o, err_o, req_o, we_o;
   logic [31:0] addr_o, wdata_o, rdata_i;
   logic        rvalid_i;

   llc_flush_seq #(.CLK_MHZ(TB_MHZ), .MAX_POLLS(TB_POLLS)) i_llc_flush_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .done_o(done_o), .err_o(err_o),
      .req_o(req_o), .we_o(we_o), .addr_o(addr_o), .wdata_o(wdata_o),
      .rdata_i(rdata_i), .rvalid_i(rvalid_i)
   );

   int n_tests = 0;
   int n_fail  = 0;
   int cyc_now = 0;

   logic [31:0] tr_addr [TRMAX];
   logic        tr_we   [TRMAX];
   logic [31:0] tr_wd   [TRMAX];
   int          tr_cyc  [TRMAX];
   int          tr_n;

   logic [31:0] ex_addr [TRMAX];
   logic        ex_we   [TRMAX];
   logic [31:0] ex_wd   [TRMAX];
   int          ex_n;

   int mode_v [NS];
   int nread  [NS];
   int dly    [2][NS];

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   initial begin
      clk = 1'b0;
      forever #5 clk = ~clk;
   end

   initial forever begin
      @(posedge clk);
      cyc_now++;
   end

   // slice register responders: one response per request, one cycle later
   initial begin
      logic        pend;
      logic [31:0] pend_data;
      pend = 1'b0; pend_data = '0;
      rvalid_i = 1'b0; rdata_i = '0; tr_n = 0;
      forever begin
         @(negedge clk);
         rvalid_i = pend;
         rdata_i  = pend_data;
         pend     = 1'b0;
         if (rst_n && req_o) begin
            int k;
            k = int'(addr_o >> 16) - 32;
            if (tr_n < TRMAX) begin
               tr_addr[tr_n] = addr_o; tr_we[tr_n] = we_o;
               tr_wd[tr_n] = wdata_o;  tr_cyc[tr_n] = cyc_now;
               tr_n++;
            end
            pend_data = 32'hDEAD_0005;
            if (k >= 0 && k < NS) begin
               if (we_o) begin
                  mode_v[k] = int'(wdata_o);
                  nread[k]  = 0;
               end else begin
                  int p;
                  p = (mode_v[k] == 3) ? 1 : 0;
                  nread[k]++;
                  if (nread[k] <= dly[p][k]) pend_data = 32'h0000_00A5;
                  else pend_data = (p == 1) ? 32'h0000_007C : 32'h0000_00F0;
               end
            end
            pend = 1'b1;
         end
      end
   end

   task automatic ex_add(input logic [31:0] a, input logic w, input logic [31:0] d);
      if (ex_n < TRMAX) begin
         ex_addr[ex_n] = a; ex_we[ex_n] = w; ex_wd[ex_n] = d;
         ex_n++;
      end
   endtask

   task automatic run_case(input bit mid_start);
      bit ok_exp, fired, fin;
      int done_cnt, mism, gap_min;
      ex_n = 0; ok_exp = 1'b1;
      for (int p = 0; p < 2; p++) begin
         if (ok_exp) begin
            for (int k = 0; k < NS; k++)
               ex_add(((32'(k) + 32'h20) << 16) + 32'h10, 1'b1, (p == 1) ? 32'd3 : 32'd0);
            for (int k = 0; k < NS; k++) begin
               if (ok_exp) begin
                  int n;
                  n = dly[p][k] + 1;
                  if (n > TB_POLLS) begin n = TB_POLLS; ok_exp = 1'b0; end
                  for (int r = 0; r < n; r++)
                     ex_add(((32'(k) + 32'h20) << 16) + 32'h18, 1'b0, 32'd0);
               end
            end
         end
      end
      for (int k = 0; k < NS; k++) begin nread[k] = 0; mode_v[k] = 255; end
      tr_n = 0;
      @(negedge clk); start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
      chk(err_o == 1'b0, "R8", "error flag after accepted start", longint'(err_o), 0);
      done_cnt = 0; fired = 1'b0; fin = 1'b0;
      for (int c = 0; c < 4000 && !fin; c++) begin
         @(negedge clk);
         if (done_o) done_cnt++;
         start_i = 1'b0;
         if (mid_start && !fired && tr_n >= 3) begin start_i = 1'b1; fired = 1'b1; end
         if (done_o || err_o) fin = 1'b1;
      end
      start_i = 1'b0;
      chk(fin, "R7", "run finished", longint'(fin), 1);
      for (int c = 0; c < 12; c++) begin
         @(negedge clk);
         if (done_o) done_cnt++;
      end
      // full request trace vs arithmetic expectation
      chk(tr_n == ex_n, ok_exp ? "R3" : "R6", "request count", tr_n, ex_n);
      mism = -1;
      for (int i = 0; i < tr_n && i < ex_n; i++)
         if (mism < 0 && (tr_addr[i] != ex_addr[i] || tr_we[i] != ex_we[i] ||
                          (ex_we[i] && tr_wd[i] != ex_wd[i]))) mism = i;
      if (mism >= 0)
         chk(1'b0, ex_we[mism] ? "R2/R4" : "R3", $sformatf("request %0d addr/we/data", mism),
             {tr_we[mism], tr_addr[mism]}, {ex_we[mism], ex_addr[mism]});
      else
         chk(1'b1, "R2", "request trace", 0, 0);
      if (mid_start) chk(mism < 0 && tr_n == ex_n, "R9", "trace unchanged by busy start", tr_n, ex_n);
      gap_min = 1000000;
      for (int i = 0; i + 1 < tr_n; i++)
         if (!tr_we[i] && !tr_we[i+1] && tr_addr[i] == tr_addr[i+1])
            if (tr_cyc[i+1] - tr_cyc[i] < gap_min) gap_min = tr_cyc[i+1] - tr_cyc[i];
      if (gap_min != 1000000) chk(gap_min >= TB_MHZ, "R5", "poll spacing", gap_min, TB_MHZ);
      if (ok_exp) begin
         chk(done_cnt == 1, "R7", "done pulse count", done_cnt, 1);
         chk(err_o == 1'b0, "R7", "error flag on clean run", longint'(err_o), 0);
      end else begin
         chk(done_cnt == 0, "R7", "done pulse on error run", done_cnt, 0);
         chk(err_o == 1'b1, "R6", "error flag after timeout", longint'(err_o), 1);
         chk(err_o == 1'b1, "R8", "error flag held while idle", longint'(err_o), 1);
      end
   endtask

   initial begin
      #2000000;
      n_fail++;
      $display("FAIL watchdog: run did not end actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      rst_n = 1'b0; start_i = 1'b0;
      for (int p = 0; p < 2; p++) for (int k = 0; k < NS; k++) dly[p][k] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(done_o == 1'b0, "R1", "done after reset", longint'(done_o), 0);
      chk(err_o == 1'b0,  "R1", "error after reset", longint'(err_o), 0);
      repeat (5) @(negedge clk);
      chk(tr_n == 0 && req_o == 1'b0, "R1", "requests before start", tr_n, 0);

      run_case(1'b0);
      for (int p = 0; p < 2; p++)
         for (int k = 0; k < NS; k++)
            for (int d = 0; d <= TB_POLLS + 1; d++) begin
               for (int q = 0; q < 2; q++) for (int j = 0; j < NS; j++) dly[q][j] = 0;
               dly[p][k] = d;
               run_case(1'b0);
            end
      for (int k = 0; k < NS; k++) begin
         dly[0][k] = k % TB_POLLS;
         dly[1][k] = (NS - 1 - k) % TB_POLLS;
      end
      run_case(1'b0);
      run_case(1'b1);
      dly[1][NS-1] = TB_POLLS;
      run_case(1'b1);

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule